// File: doc/BRIEF.md
# Clock-aligned single-pulse and edge detector

This block turns a level input that may change at any time into output pulses exactly one clock period wide, aligned to the rising edge of `clk`. Two flip-flops sample the input one after the other, and a small decoder compares their contents. In rising-only mode the block fires once for each low-to-high change that the clock sees, no matter how long the input then stays high. In both-edges mode it fires once for every sampled change in either direction.

A trigger can rise and fall again between two clock edges. Such a trigger is normally missed. An optional catch stage stores the rising edge of a trigger like this until the next clock edge, so the trigger is not lost. The stored event is cleared on the same edge that takes it in. The block has no data stream: every pin is a plain control or status line, so no valid/ready handshake is used.

Top module: `sync_pulse_gen`

## Requirements
- R1: While `rst_n` is low, both sampling stages are held at 0 and `pulse_out` is 0, whatever `trig_in` does. The first clock edge after release compares the input against a stored 0.
- R2: Every pulse on `pulse_out` in rising-only mode lasts exactly one clock period. A trigger held high for many cycles gives a single pulse.
- R3: With `edge_both` = 0, `pulse_out` is 1 during the cycle after an edge where `trig_in` is sampled 1, provided the edge before it sampled `trig_in` as 0. Otherwise `pulse_out` is 0.
- R4: With `edge_both` = 1, `pulse_out` is 1 during the cycle after any edge whose sample of `trig_in` differs from the previous sample. Rising and falling changes each give one pulse.
- R5: With `catch_short` = 0, a high pulse on `trig_in` that starts and ends between two rising clock edges has no effect on `pulse_out`.
- R6: With `catch_short` = 1, a rising edge of `trig_in` that occurs between two clock edges makes the next clock edge sample the trigger as 1. A short trigger then gives one pulse in rising-only mode and two pulses (rise and fall) in both-edges mode.
- R7: The stored short-trigger event is cleared on the clock edge that samples it. Once it has been taken in, later edges produce no further pulses unless a new trigger arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Trigger level, may change at any time |
| edge_both | input | 1 | 0 = pulse on rising changes only, 1 = pulse on every change |
| catch_short | input | 1 | 1 = store triggers shorter than a clock period |
| pulse_out | output | 1 | One-clock-wide output pulse |

## Verification
The clocked properties assume that `trig_in` is stable around each rising edge of `clk`, so the value a property reads with `$past` is the same value the first stage took in. They also assume that any short trigger they judge happens while `catch_short` is low. The stimulus changes inputs just after the falling edge and places short triggers well before the next rising edge, so every change falls inside a quiet window. The bench still checks the short-trigger behaviour with `catch_short` high through its own scoreboard, because no property can express it.

// File: rtl/sync_pulse_pkg.sv
package sync_pulse_pkg;
  typedef enum logic {
    MODE_RISE_ONLY = 1'b0,
    MODE_ANY_EDGE  = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/edge_catch.sv
// Stores a rising trigger edge that may fall again before the clock sees it.
// A toggle in the trigger domain and an acknowledge copy in the clock domain
// keep each flop driven from one clock only; a mismatch means an event waits.
module edge_catch #(
  parameter bit PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic arm,
  output logic held
);
  generate
    if (PRESENT) begin : g_store
      logic tog_q;
      logic ack_q;
      always_ff @(posedge trig_in or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
      end
      // Acknowledge every edge: the waiting event is consumed where sampled.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= 1'b0;
        else        ack_q <= tog_q;
      end
      assign held = arm & (tog_q ^ ack_q);
    end else begin : g_none
      logic unused_in;
      assign unused_in = ^{clk, rst_n, trig_in, arm};
      assign held = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/edge_stages.sv
// Two sampling flops: newest sample and the one before it.
module edge_stages (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic s_new,
  output logic s_old
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_new <= 1'b0;
      s_old <= 1'b0;
    end else begin
      s_new <= d_in;
      s_old <= s_new;
    end
  end
endmodule

// File: rtl/edge_decode.sv
module edge_decode
  import sync_pulse_pkg::*;
(
  input  edge_mode_e mode,
  input  logic       s_new,
  input  logic       s_old,
  output logic       pulse
);
  always_comb begin
    unique case (mode)
      MODE_ANY_EDGE:  pulse = s_new ^ s_old;
      default:        pulse = s_new & ~s_old;
    endcase
  end
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sync_pulse_pkg::*;
#(
  parameter bit CATCH_PRESENT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic edge_both,
  input  logic catch_short,
  output logic pulse_out
);
  logic       held_evt;
  logic       stage_d;
  logic       samp_new;
  logic       samp_old;
  edge_mode_e mode_sel;

  edge_catch #(.PRESENT(CATCH_PRESENT)) catch_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .arm     (catch_short),
    .held    (held_evt)
  );

  assign stage_d = trig_in | held_evt;

  edge_stages stages_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (stage_d),
    .s_new (samp_new),
    .s_old (samp_old)
  );

  assign mode_sel = edge_both ? MODE_ANY_EDGE : MODE_RISE_ONLY;

  edge_decode decode_i (
    .mode  (mode_sel),
    .s_new (samp_new),
    .s_old (samp_old),
    .pulse (pulse_out)
  );
endmodule

// File: rtl/sync_pulse_gen_chk.sv
module sync_pulse_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_in,
  input logic edge_both,
  input logic catch_short,
  input logic pulse_out
);
  // Edges seen since reset release, saturating at 3.
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1: output quiet while reset is held
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !pulse_out);

  // R2: a rising-mode pulse never lasts beyond one cycle
  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out && !edge_both) |=> (!pulse_out || edge_both));

  // R3 / R5: rising mode follows the sampled 0->1 change, short triggers ignored
  assert_rise_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && !edge_both && !$past(catch_short) && !$past(catch_short, 2))
      |-> (pulse_out == ($past(trig_in) && !$past(trig_in, 2))));

  // R4: both-edge mode follows any sampled change
  assert_any_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && edge_both && !$past(catch_short) && !$past(catch_short, 2))
      |-> (pulse_out == ($past(trig_in) ^ $past(trig_in, 2))));
endmodule

bind sync_pulse_gen sync_pulse_gen_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_in     (trig_in),
  .edge_both   (edge_both),
  .catch_short (catch_short),
  .pulse_out   (pulse_out)
);

// File: tb/sync_pulse_gen_tb_top.sv
module sync_pulse_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  typedef struct {
    logic  exp_y;
    string tag;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_in = 1'b0;
  logic edge_both = 1'b0;
  logic catch_short = 1'b0;
  logic pulse_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  exp_item_t sb_q[$];

  // Model state derived from the requirements
  logic m_new = 1'b0;
  logic m_old = 1'b0;
  logic cfg_both = 1'b0;
  logic cfg_catch = 1'b0;

  sync_pulse_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_in     (trig_in),
    .edge_both   (edge_both),
    .catch_short (catch_short),
    .pulse_out   (pulse_out)
  );

  initial forever #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pulse_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle of stimulus: level for the coming edge, optional short pulse.
  task automatic step(input logic lvl, input logic short_pulse, input string tag);
    exp_item_t it;
    logic samp;
    @(negedge clk);
    #1;
    edge_both   = cfg_both;
    catch_short = cfg_catch;
    trig_in     = lvl;
    if (short_pulse && !lvl) begin
      #1 trig_in = 1'b1;
      #1 trig_in = 1'b0;
    end
    samp  = lvl | (short_pulse & cfg_catch);
    m_old = m_new;
    m_new = samp;
    it.exp_y = cfg_both ? (m_new ^ m_old) : (m_new & ~m_old);
    it.tag   = tag;
    sb_q.push_back(it);
  endtask

  task automatic hold(input logic lvl, input int n, input string tag);
    for (int i = 0; i < n; i++) step(lvl, 1'b0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst_n   = 1'b0;
    trig_in = 1'b1;
    #1 check(pulse_out, 1'b0, "R1 reset entry");
    @(negedge clk);
    #1 check(pulse_out, 1'b0, "R1 reset with trigger high");
    trig_in = 1'b0;
    @(negedge clk);
    #1 check(pulse_out, 1'b0, "R1 reset with trigger low");
    m_new = 1'b0;
    m_old = 1'b0;
    rst_n = 1'b1;
  endtask

  // Monitor: compare after each rising edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_item_t it;
      it = sb_q.pop_front();
      check(pulse_out, it.exp_y, it.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    hold(1'b0, 3, "R1 idle after release");

    // Rising mode, no catch
    cfg_both = 1'b0; cfg_catch = 1'b0;
    hold(1'b1, 6, "R2 long trigger one pulse");
    hold(1'b0, 1, "R3 low one cycle");
    hold(1'b1, 3, "R3 re-armed rise");
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, "R3 alternating low");
      step(1'b1, 1'b0, "R3 alternating high");
    end
    hold(1'b0, 2, "R3 settle");
    step(1'b0, 1'b1, "R5 short trigger ignored");
    hold(1'b0, 3, "R5 no late pulse");

    // Rising mode with catch
    cfg_catch = 1'b1;
    step(1'b0, 1'b1, "R6 short trigger caught");
    hold(1'b0, 4, "R7 event consumed");
    step(1'b0, 1'b1, "R6 second short trigger");
    hold(1'b0, 2, "R7 event consumed again");

    // Both-edge mode, no catch
    cfg_both = 1'b1; cfg_catch = 1'b0;
    hold(1'b0, 2, "R4 quiet");
    hold(1'b1, 3, "R4 rise then hold");
    hold(1'b0, 3, "R4 fall then hold");
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 1'b0, "R4 toggle high");
      step(1'b0, 1'b0, "R4 toggle low");
    end
    step(1'b0, 1'b1, "R5 short trigger ignored both-edge");
    hold(1'b0, 2, "R5 settle both-edge");

    // Both-edge mode with catch
    cfg_catch = 1'b1;
    step(1'b0, 1'b1, "R6 caught trigger gives rise pulse");
    hold(1'b0, 3, "R6 fall pulse then quiet");

    // Reset in mid-run
    cfg_both = 1'b0; cfg_catch = 1'b0;
    hold(1'b1, 2, "R2 before reset");
    do_reset();
    hold(1'b0, 2, "R1 quiet after second reset");
    hold(1'b1, 2, "R3 rise after reset");
    hold(1'b0, 2, "R3 end");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule